// File: doc/BRIEF.md
# Memory Window Address Translator

One translation window of a card-socket controller. Three 16-bit registers hold a window base, a card-mapping offset and a control word. A host memory address of 24 bits is compared with the programmed base. The window size is encoded inside the base field itself: the lowest set bit of that field marks the size, and that bit and every bit below it are left out of the compare. When the window is enabled and the address falls inside it, the block signals a hit. On a hit, the card address is formed by adding the mapping offset to the host page number. Because the mapping is an addition and not a replacement, mapping a window onto card page zero needs the two's complement of the window base.

The block also drives the control attributes for the cycle: socket select, wait count, write prohibit and forced 8-bit width. It also drives an attribute-space flag taken from the map register. A write to the base register switches the window off, so a window can never hit while its base is half updated. The hardware sets an accessed flag in the control word whenever the window serves a valid cycle. Software can clear that flag by rewriting the control word. A write cycle through a write-prohibited window is not passed to the card.

Top module: `mwin_translator`

## Requirements
- R1: After reset all three registers read 0, and no hit or card write is signalled.
- R2: Register select 0 is the base, 1 is the map and 2 is the control register. A write loads all 16 bits, and the register reads back on `reg_rdata_o` in the same cycle it is selected. Select 3 reads 0, and a write with select 3 changes no register.
- R3: The compare vector is {base[11:0], base[14]}, aligned to host address bits 23:11. If its lowest set bit is bit p, address bits 11+p and below are ignored. The window covers host addresses from (vector with bit p cleared) << 11, spanning 2^(12+p) bytes.
- R4: A compare vector of all zeros never hits.
- R5: `hit_o` is 1 only when `acc_valid_i` is 1, control bit 15 (enable) is 1 and the address lies in the window. It is combinational in the same cycle.
- R6: A write to the base register clears control bit 15 at that clock edge and leaves the other control bits unchanged.
- R7: `card_addr_o[25:12]` = (host address[23:12] + map[13:0]) mod 2^14, and `card_addr_o[11:0]` = host address[11:0].
- R8: `attr_space_o` = map bit 15, `socket_o` = control bits 14:12, `wait_cnt_o` = control bits 4:0, `force8_o` = control bit 11 and `wr_protect_o` = control bit 7.
- R9: A cycle with `acc_valid_i` and `hit_o` both 1 sets control bit 8 (accessed) at the next clock edge. A control write in the same cycle takes priority over this set.
- R10: `card_we_o` is 1 only for a hit with `acc_write_i` 1 and control bit 7 (write prohibit) 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select (0 base, 1 map, 2 control) |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Readback of the selected register |
| acc_valid_i | input | 1 | Host memory cycle present |
| acc_write_i | input | 1 | Host cycle is a write |
| acc_addr_i | input | 24 | Host memory address |
| hit_o | output | 1 | Window claims the cycle |
| card_we_o | output | 1 | Write is forwarded to the card |
| card_addr_o | output | 26 | Translated card address |
| attr_space_o | output | 1 | Attribute-space select |
| socket_o | output | 3 | Socket select |
| wait_cnt_o | output | 5 | Wait-state count |
| wr_protect_o | output | 1 | Window is write prohibited |
| force8_o | output | 1 | Force 8-bit cycle |

## Verification
The following outputs are combinational and are due in the same cycle the address or registers present them: hit, card address, attributes, card write and readback. The bench drives inputs on the falling edge and samples these outputs 1 ns later. Register effects are due at the next rising edge. These effects are register loads, the enable clear on a base write, and the accessed-flag set. The bench reads them back only after the following falling edge, so exactly one rising edge lies between the stimulus and the sample. The same-cycle race between a hit and a control write is driven on a single edge, so the priority between them is what gets observed.

// File: rtl/mwin_pkg.sv
package mwin_pkg;
  localparam int HOST_AW  = 24;
  localparam int FINE_LSB = 11;
  localparam int PAGE_LSB = 12;
  localparam int CARD_AW  = 26;
  localparam int RW       = 16;
  localparam int MAP_W    = CARD_AW - PAGE_LSB;
  localparam int CMP_W    = HOST_AW - FINE_LSB;
  localparam int PAGE_W   = HOST_AW - PAGE_LSB;

  localparam int BASE_FINE_BIT = 14;
  localparam int MAP_ATTR_BIT  = 15;
  localparam int CTRL_EN_BIT   = 15;
  localparam int CTRL_ACC_BIT  = 8;
  localparam int CTRL_WP_BIT   = 7;
  localparam int CTRL_B8_BIT   = 11;
  localparam int CTRL_SS_LSB   = 12;
  localparam int SS_W          = 3;
  localparam int WS_W          = 5;

  typedef enum logic [1:0] {
    SEL_BASE = 2'd0,
    SEL_MAP  = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/mwin_regs.sv
module mwin_regs
  import mwin_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  reg_sel_e      sel_i,
  input  logic [RW-1:0] wdata_i,
  input  logic          hit_set_i,
  output logic [RW-1:0] base_o,
  output logic [RW-1:0] map_o,
  output logic [RW-1:0] ctrl_o,
  output logic [RW-1:0] rdata_o
);
  logic [RW-1:0] base_q, map_q, ctrl_q;
  logic [RW-1:0] ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (hit_set_i) ctrl_d[CTRL_ACC_BIT] = 1'b1;
    if (we_i && sel_i == SEL_BASE) ctrl_d[CTRL_EN_BIT] = 1'b0;
    // software write wins over the hardware accessed set
    if (we_i && sel_i == SEL_CTRL) ctrl_d = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      map_q  <= '0;
      ctrl_q <= '0;
    end else begin
      if (we_i && sel_i == SEL_BASE) base_q <= wdata_i;
      if (we_i && sel_i == SEL_MAP)  map_q  <= wdata_i;
      ctrl_q <= ctrl_d;
    end
  end

  always_comb begin
    unique case (sel_i)
      SEL_BASE: rdata_o = base_q;
      SEL_MAP:  rdata_o = map_q;
      SEL_CTRL: rdata_o = ctrl_q;
      default:  rdata_o = '0;
    endcase
  end

  assign base_o = base_q;
  assign map_o  = map_q;
  assign ctrl_o = ctrl_q;

  // R6
  base_wr_disables_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == SEL_BASE) |=> !ctrl_q[CTRL_EN_BIT]);

  // R9
  acc_flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_set_i && !(we_i && sel_i == SEL_CTRL)) |=> ctrl_q[CTRL_ACC_BIT]);

  // R2
  null_sel_inert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == SEL_NONE) |=> ($stable(base_q) && $stable(map_q)));
endmodule

// File: rtl/mwin_match.sv
module mwin_match
  import mwin_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [RW-1:0]       base_i,
  input  logic [HOST_AW-1:0]  addr_i,
  output logic                match_o
);
  logic [CMP_W-1:0] field, seen, care;

  assign field = {base_i[PAGE_W-1:0], base_i[BASE_FINE_BIT]};

  // prefix-OR from the bottom: a bit is compared only if a set bit lies below it
  assign seen[0] = field[0];
  assign care[0] = 1'b0;
  for (genvar i = 1; i < CMP_W; i++) begin : g_scan
    assign seen[i] = seen[i-1] | field[i];
    assign care[i] = seen[i-1];
  end

  assign match_o = seen[CMP_W-1] &&
                   (((addr_i[HOST_AW-1:FINE_LSB] ^ field) & care) == '0);

  // R4
  empty_field_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (field == '0) |-> !match_o);
endmodule

// File: rtl/mwin_xlate.sv
module mwin_xlate
  import mwin_pkg::*;
(
  input  logic [HOST_AW-1:0] addr_i,
  input  logic [RW-1:0]      map_i,
  output logic [CARD_AW-1:0] card_addr_o
);
  logic [MAP_W-1:0] page_ext, page_sum;

  assign page_ext    = MAP_W'(addr_i[HOST_AW-1:PAGE_LSB]);
  assign page_sum    = page_ext + map_i[MAP_W-1:0];
  assign card_addr_o = {page_sum, addr_i[PAGE_LSB-1:0]};
endmodule

// File: rtl/mwin_translator.sv
module mwin_translator
  import mwin_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reg_we_i,
  input  logic [1:0]           reg_sel_i,
  input  logic [15:0]          reg_wdata_i,
  output logic [15:0]          reg_rdata_o,
  input  logic                 acc_valid_i,
  input  logic                 acc_write_i,
  input  logic [23:0]          acc_addr_i,
  output logic                 hit_o,
  output logic                 card_we_o,
  output logic [25:0]          card_addr_o,
  output logic                 attr_space_o,
  output logic [2:0]           socket_o,
  output logic [4:0]           wait_cnt_o,
  output logic                 wr_protect_o,
  output logic                 force8_o
);
  logic [RW-1:0] base_w, map_w, ctrl_w;
  logic          match_w, hit_w;

  mwin_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .sel_i     (reg_sel_e'(reg_sel_i)),
    .wdata_i   (reg_wdata_i),
    .hit_set_i (hit_w),
    .base_o    (base_w),
    .map_o     (map_w),
    .ctrl_o    (ctrl_w),
    .rdata_o   (reg_rdata_o)
  );

  mwin_match u_match (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .base_i  (base_w),
    .addr_i  (acc_addr_i),
    .match_o (match_w)
  );

  mwin_xlate u_xlate (
    .addr_i      (acc_addr_i),
    .map_i       (map_w),
    .card_addr_o (card_addr_o)
  );

  assign hit_w        = acc_valid_i && ctrl_w[CTRL_EN_BIT] && match_w;
  assign hit_o        = hit_w;
  assign card_we_o    = hit_w && acc_write_i && !ctrl_w[CTRL_WP_BIT];
  assign attr_space_o = map_w[MAP_ATTR_BIT];
  assign socket_o     = ctrl_w[CTRL_SS_LSB +: SS_W];
  assign wait_cnt_o   = ctrl_w[WS_W-1:0];
  assign wr_protect_o = ctrl_w[CTRL_WP_BIT];
  assign force8_o     = ctrl_w[CTRL_B8_BIT];

  // R5
  idle_no_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |-> !hit_o);

  // R10
  wp_blocks_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_write_i && wr_protect_o) |-> !card_we_o);

  // R10
  card_we_needs_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    card_we_o |-> (hit_o && acc_write_i));
endmodule

// File: tb/tb_mwin_translator.sv
module tb_mwin_translator;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [23:0] acc_addr = '0;
  logic        hit, card_we, attr_space, wr_protect, force8;
  logic [25:0] card_addr;
  logic [2:0]  socket;
  logic [4:0]  wait_cnt;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mwin_translator dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .reg_we_i(reg_we), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata),
    .acc_valid_i(acc_valid), .acc_write_i(acc_write), .acc_addr_i(acc_addr),
    .hit_o(hit), .card_we_o(card_we), .card_addr_o(card_addr),
    .attr_space_o(attr_space), .socket_o(socket), .wait_cnt_o(wait_cnt),
    .wr_protect_o(wr_protect), .force8_o(force8)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [15:0] data);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [1:0] sel, logic [15:0] exp);
    @(negedge clk);
    reg_sel = sel;
    #1 chk(req, 32'(reg_rdata), 32'(exp));
  endtask

  // drive an access for one cycle, sample 1 ns into it, then drop it
  task automatic access(logic [23:0] a, logic w);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = w; acc_addr = a;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    chk("R1 hit", 32'(hit), 0);
    chk("R1 card_we", 32'(card_we), 0);
    rd_chk("R1 base", 2'd0, 16'h0);
    rd_chk("R1 map", 2'd1, 16'h0);
    rd_chk("R1 ctrl", 2'd2, 16'h0);
  endtask

  task automatic t_regs();
    wr(2'd0, 16'h1234);
    wr(2'd1, 16'h5678);
    wr(2'd2, 16'h0A5A);
    rd_chk("R2 base", 2'd0, 16'h1234);
    rd_chk("R2 map", 2'd1, 16'h5678);
    rd_chk("R2 ctrl", 2'd2, 16'h0A5A);
    wr(2'd3, 16'hFFFF);
    rd_chk("R2 sel3 reads 0", 2'd3, 16'h0);
    rd_chk("R2 base after sel3", 2'd0, 16'h1234);
    rd_chk("R2 map after sel3", 2'd1, 16'h5678);
    rd_chk("R2 ctrl after sel3", 2'd2, 16'h0A5A);
  endtask

  // 4K window at 0xD0000 mapped onto card page 0
  task automatic t_win4k();
    wr(2'd0, 16'h40D0);
    wr(2'd1, 16'h3F30);
    wr(2'd2, 16'hA805);
    access(24'hD0123, 1'b0);
    chk("R3 4K low hit", 32'(hit), 1);
    chk("R7 card addr page0", 32'(card_addr), 32'h000123);
    chk("R8 socket", 32'(socket), 2);
    chk("R8 wait", 32'(wait_cnt), 5);
    chk("R8 force8", 32'(force8), 1);
    chk("R8 attr off", 32'(attr_space), 0);
    access(24'hD0FFF, 1'b0);
    chk("R3 4K top hit", 32'(hit), 1);
    access(24'hD1000, 1'b0);
    chk("R3 4K above miss", 32'(hit), 0);
    access(24'hCFFFF, 1'b0);
    chk("R3 4K below miss", 32'(hit), 0);
    idle();
    #1 chk("R5 no valid no hit", 32'(hit), 0);
  endtask

  task automatic t_enable();
    wr(2'd2, 16'hA805);
    wr(2'd0, 16'h40D0);
    rd_chk("R6 enable cleared", 2'd2, 16'h2805);
    access(24'hD0123, 1'b0);
    chk("R5 disabled no hit", 32'(hit), 0);
    idle();
  endtask

  task automatic t_accessed();
    wr(2'd2, 16'hA805);
    access(24'hD0200, 1'b0);
    idle();
    rd_chk("R9 accessed set", 2'd2, 16'hA905);
    wr(2'd2, 16'hA805);
    rd_chk("R9 software clear", 2'd2, 16'hA805);
    // hit and control write on the same edge
    @(negedge clk);
    reg_we = 1'b1; reg_sel = 2'd2; reg_wdata = 16'hA805;
    acc_valid = 1'b1; acc_write = 1'b0; acc_addr = 24'hD0200;
    @(negedge clk);
    reg_we = 1'b0; acc_valid = 1'b0;
    rd_chk("R9 write wins", 2'd2, 16'hA805);
  endtask

  // 64K window at 0x20000, attribute space, card page offset 0x100
  task automatic t_win64k();
    wr(2'd0, 16'h0028);
    wr(2'd1, 16'h8100);
    wr(2'd2, 16'h8000);
    access(24'h2ABCD, 1'b0);
    chk("R3 64K mid hit", 32'(hit), 1);
    chk("R7 card addr offset", 32'(card_addr), 32'h12ABCD);
    chk("R8 attr on", 32'(attr_space), 1);
    access(24'h20000, 1'b0);
    chk("R3 64K first hit", 32'(hit), 1);
    access(24'h2FFFF, 1'b0);
    chk("R3 64K last hit", 32'(hit), 1);
    access(24'h30000, 1'b0);
    chk("R3 64K above miss", 32'(hit), 0);
    access(24'h1FFFF, 1'b0);
    chk("R3 64K below miss", 32'(hit), 0);
    idle();
  endtask

  task automatic t_wrap();
    wr(2'd0, 16'h40D0);
    wr(2'd1, 16'h3FFF);
    wr(2'd2, 16'h8000);
    access(24'hD0123, 1'b0);
    chk("R7 sum truncated", 32'(card_addr), 32'h0CF123);
    idle();
  endtask

  task automatic t_zero();
    wr(2'd0, 16'h0000);
    wr(2'd2, 16'h8000);
    access(24'h000000, 1'b0);
    chk("R4 zero field at 0", 32'(hit), 0);
    access(24'h123456, 1'b0);
    chk("R4 zero field elsewhere", 32'(hit), 0);
    idle();
  endtask

  task automatic t_wp();
    wr(2'd0, 16'h40D0);
    wr(2'd2, 16'h8080);
    access(24'hD0010, 1'b1);
    chk("R10 wp hit", 32'(hit), 1);
    chk("R10 wp blocks write", 32'(card_we), 0);
    chk("R8 wp flag", 32'(wr_protect), 1);
    idle();
    wr(2'd2, 16'h8000);
    access(24'hD0010, 1'b1);
    chk("R10 write passes", 32'(card_we), 1);
    access(24'hD0010, 1'b0);
    chk("R10 read no card_we", 32'(card_we), 0);
    access(24'hD1010, 1'b1);
    chk("R10 miss no card_we", 32'(card_we), 0);
    idle();
  endtask

  initial begin
    #12 rst_ni = 1'b1;
    t_reset();
    t_regs();
    t_win4k();
    t_enable();
    t_accessed();
    t_win64k();
    t_wrap();
    t_zero();
    t_wp();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule